// File: doc/BRIEF.md
# Low-Power Mode Sequencer

The sequencer is the state machine that moves a small microcontroller between four modes. In run mode the CPU executes. In wait mode only the CPU clock is stopped. In active-halt the CPU is stopped and the slow oscillator keeps running for the wakeup timer and the independent watchdog. In full halt every clock is stopped. The core makes requests and the sequencer answers them by driving the CPU clock enable, the two regulator enables (main and low-power), the flash power-down control and the three oscillator enables. It also selects the master clock.

Before a halt, the configuration bits are sampled once. They decide which regulator holds the supply, whether the flash is powered down, and whether the device resumes on the internal RC oscillator instead of the clock it used before. Each wakeup from a halt mode passes through three ordered steps before the CPU clock returns: regulator ready, then flash ready, then clock ready. A crystal clock is counted out over a fixed number of oscillator cycles. The analog parts are modelled only as ready inputs and ticks.

Top module: `lpm_seq`

## Requirements
- R1: After synchronous reset `pm_state` is 0 (run), `cpu_clk_en`=1, `mvr_en`=1, `lpvr_en`=0, `flash_pd`=0, `master_clk`=0 (internal RC) and only `rc_osc_en` of the three oscillator enables is 1. State codes: 0 run, 1 wait, 2 active-halt, 3 full halt, 4 wake-regulator, 5 wake-flash, 6 wake-clock.
- R2: `wfi_req` in run (without `halt_req`) moves to wait on the next edge. Wait clears only `cpu_clk_en`; the regulators, flash and oscillators keep their run values. `int_unmask` is 1 in exactly the first wait cycle.
- R3: In wait, `irq_any` returns to run on the next edge. `halt_req`, `wfi_req` and clock switch requests in wait are ignored.
- R4: `halt_req` in run enters active-halt (2) when `awu_en` or `iwdg_en` is 1 and full halt (3) otherwise. `halt_req` has priority over `wfi_req`.
- R5: In active-halt the low-power regulator is used if `cfg_ah_lowreg` was 1 at entry, otherwise the main regulator is used. Full halt always uses the low-power regulator. Exactly one of `mvr_en`/`lpvr_en` is 1 at all times.
- R6: `flash_pd` equals `cfg_ah_flash_off` (sampled at entry) in active-halt and the inverse of `cfg_halt_flash_on` in full halt. Bit changes during a halt have no effect.
- R7: In full halt all oscillator enables are 0. In active-halt only `slow_osc_en` is 1. In run and wait only the enable matching `master_clk` is 1.
- R8: Full halt is left only on `ext_wake_irq`; `awu_event` and `irq_any` are ignored there. Active-halt is left on `ext_wake_irq` or `awu_event`. Both go to state 4.
- R9: Wakeup goes 4→5 on `reg_ready`, 5→6 on `flash_ready`, and 6→0 on clock ready, each step on the edge where its input is 1. `cpu_clk_en` stays 0 throughout, and `mvr_en`=1 in states 4 to 6.
- R10: If `cfg_fast_wake` is 1 when a halt is entered, `master_clk` becomes 0 (internal RC) on entry and the wake uses the RC clock.
- R11: When the wake clock is the crystal (`master_clk`=1), state 6 lasts exactly XTAL_SETTLE `xtal_tick` pulses and ignores `clk_ready`. For RC (0) and slow (2) clocks, state 6 ends on `clk_ready`.
- R12: `clk_sw_req` in run loads `clk_sw_sel` into `master_clk` on the next edge (0 RC, 1 crystal, 2 slow RC). Code 3 is ignored. When the request coincides with `halt_req`, the switch still applies unless `cfg_fast_wake` forces the RC clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| wfi_req | input | 1 | Core requests wait mode |
| halt_req | input | 1 | Core requests a halt |
| awu_en | input | 1 | Wakeup timer enabled |
| iwdg_en | input | 1 | Independent watchdog enabled |
| cfg_ah_lowreg | input | 1 | Use low-power regulator in active-halt |
| cfg_ah_flash_off | input | 1 | Power down flash in active-halt |
| cfg_halt_flash_on | input | 1 | Keep flash on in full halt |
| cfg_fast_wake | input | 1 | Resume on internal RC after a halt |
| clk_sw_req | input | 1 | Master clock switch request |
| clk_sw_sel | input | 2 | Requested master clock code |
| irq_any | input | 1 | Any interrupt (wait exit) |
| ext_wake_irq | input | 1 | External or peripheral wakeup interrupt |
| awu_event | input | 1 | Wakeup timer expiry |
| reg_ready | input | 1 | Main regulator settled |
| flash_ready | input | 1 | Flash powered up |
| clk_ready | input | 1 | Internal RC clock stable |
| xtal_tick | input | 1 | One crystal oscillator cycle elapsed |
| pm_state | output | 3 | Current state code |
| cpu_clk_en | output | 1 | CPU clock enable |
| mvr_en | output | 1 | Main regulator enable |
| lpvr_en | output | 1 | Low-power regulator enable |
| flash_pd | output | 1 | Flash power-down |
| rc_osc_en | output | 1 | Internal 16 MHz RC enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| slow_osc_en | output | 1 | Slow internal RC enable |
| master_clk | output | 2 | Master clock select |
| int_unmask | output | 1 | Interrupts enabled on wait entry |

## Verification
Two functions can fall in the same cycle. A master clock switch request and a halt request can arrive together, and so can a wait request and a halt request. The bench raises `clk_sw_req` and `halt_req` together, once with fast wake clear and once with it set. It checks that the new clock code survives into the halt in the first case and is overridden by the RC code in the second. It also raises `wfi_req` and `halt_req` together and expects the halt state code and no `int_unmask` pulse. All 32 combinations of the two enables and three configuration bits are swept through entry and exit of a halt.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        PM_RUN      = 3'd0,
        PM_WAIT     = 3'd1,
        PM_AHALT    = 3'd2,
        PM_HALT     = 3'd3,
        PM_WK_REG   = 3'd4,
        PM_WK_FLASH = 3'd5,
        PM_WK_CLK   = 3'd6
    } pm_state_e;

    typedef enum logic [1:0] {
        CK_RC   = 2'd0,
        CK_XTAL = 2'd1,
        CK_SLOW = 2'd2
    } clk_src_e;

    // Settings captured once when a halt is entered
    typedef struct packed {
        logic lp_reg;
        logic flash_off;
    } halt_cfg_t;

    typedef struct packed {
        logic cpu_clk_en;
        logic mvr_en;
        logic lpvr_en;
        logic flash_pd;
        logic rc_en;
        logic xtal_en;
        logic slow_en;
    } pwr_ctrl_t;

    function automatic logic clk_code_ok(input logic [1:0] code);
        return code != 2'd3;
    endfunction

endpackage

// File: rtl/lpm_xtal_timer.sv
module lpm_xtal_timer #(
    parameter int XTAL_SETTLE = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(XTAL_SETTLE + 1);
    localparam logic [CW-1:0] LAST = CW'(XTAL_SETTLE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == LAST);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wfi_req,
    input  logic       halt_req,
    input  logic       awu_en,
    input  logic       iwdg_en,
    input  logic       cfg_ah_lowreg,
    input  logic       cfg_ah_flash_off,
    input  logic       cfg_halt_flash_on,
    input  logic       cfg_fast_wake,
    input  logic       clk_sw_req,
    input  logic [1:0] clk_sw_sel,
    input  logic       irq_any,
    input  logic       ext_wake_irq,
    input  logic       awu_event,
    input  logic       reg_ready,
    input  logic       flash_ready,
    input  logic       clk_ok,
    output pm_state_e  state,
    output clk_src_e   cur_clk,
    output halt_cfg_t  hcfg,
    output logic       int_unmask
);
    pm_state_e nxt;
    clk_src_e  nclk;
    halt_cfg_t ncfg;
    logic      nunmask;
    logic      sw_ok;
    logic      to_active;

    assign sw_ok     = clk_sw_req && clk_code_ok(clk_sw_sel);
    assign to_active = awu_en || iwdg_en;

    always_comb begin
        nxt     = state;
        nclk    = cur_clk;
        ncfg    = hcfg;
        nunmask = 1'b0;
        unique case (state)
            PM_RUN: begin
                if (halt_req) begin
                    nxt            = to_active ? PM_AHALT : PM_HALT;
                    ncfg.lp_reg    = to_active ? cfg_ah_lowreg : 1'b1;
                    ncfg.flash_off = to_active ? cfg_ah_flash_off : !cfg_halt_flash_on;
                    if (cfg_fast_wake)  nclk = CK_RC;
                    else if (sw_ok)     nclk = clk_src_e'(clk_sw_sel);
                end else begin
                    if (sw_ok) nclk = clk_src_e'(clk_sw_sel);
                    if (wfi_req) begin
                        nxt     = PM_WAIT;
                        nunmask = 1'b1;
                    end
                end
            end
            PM_WAIT:     if (irq_any) nxt = PM_RUN;
            PM_AHALT:    if (ext_wake_irq || awu_event) nxt = PM_WK_REG;
            PM_HALT:     if (ext_wake_irq) nxt = PM_WK_REG;
            PM_WK_REG:   if (reg_ready) nxt = PM_WK_FLASH;
            PM_WK_FLASH: if (flash_ready) nxt = PM_WK_CLK;
            PM_WK_CLK:   if (clk_ok) nxt = PM_RUN;
            default:     nxt = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PM_RUN;
            cur_clk    <= CK_RC;
            hcfg       <= '0;
            int_unmask <= 1'b0;
        end else begin
            state      <= nxt;
            cur_clk    <= nclk;
            hcfg       <= ncfg;
            int_unmask <= nunmask;
        end
    end
endmodule

// File: rtl/lpm_power_decode.sv
module lpm_power_decode
    import lpm_pkg::*;
(
    input  pm_state_e state,
    input  clk_src_e  cur_clk,
    input  halt_cfg_t hcfg,
    output pwr_ctrl_t ctl
);
    logic rc_sel, xtal_sel, slow_sel;

    assign rc_sel   = (cur_clk == CK_RC);
    assign xtal_sel = (cur_clk == CK_XTAL);
    assign slow_sel = (cur_clk == CK_SLOW);

    always_comb begin
        ctl = '0;
        ctl.mvr_en = 1'b1;
        unique case (state)
            PM_RUN, PM_WAIT: begin
                ctl.cpu_clk_en = (state == PM_RUN);
                ctl.rc_en      = rc_sel;
                ctl.xtal_en    = xtal_sel;
                ctl.slow_en    = slow_sel;
            end
            PM_AHALT, PM_HALT: begin
                ctl.mvr_en   = !hcfg.lp_reg;
                ctl.lpvr_en  = hcfg.lp_reg;
                ctl.flash_pd = hcfg.flash_off;
                ctl.slow_en  = (state == PM_AHALT);
            end
            PM_WK_REG: ctl.flash_pd = hcfg.flash_off;
            PM_WK_CLK: begin
                ctl.rc_en   = rc_sel;
                ctl.xtal_en = xtal_sel;
                ctl.slow_en = slow_sel;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int XTAL_SETTLE = 2048
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wfi_req,
    input  logic       halt_req,
    input  logic       awu_en,
    input  logic       iwdg_en,
    input  logic       cfg_ah_lowreg,
    input  logic       cfg_ah_flash_off,
    input  logic       cfg_halt_flash_on,
    input  logic       cfg_fast_wake,
    input  logic       clk_sw_req,
    input  logic [1:0] clk_sw_sel,
    input  logic       irq_any,
    input  logic       ext_wake_irq,
    input  logic       awu_event,
    input  logic       reg_ready,
    input  logic       flash_ready,
    input  logic       clk_ready,
    input  logic       xtal_tick,
    output logic [2:0] pm_state,
    output logic       cpu_clk_en,
    output logic       mvr_en,
    output logic       lpvr_en,
    output logic       flash_pd,
    output logic       rc_osc_en,
    output logic       xtal_osc_en,
    output logic       slow_osc_en,
    output logic [1:0] master_clk,
    output logic       int_unmask
);
    pm_state_e state;
    clk_src_e  cur_clk;
    halt_cfg_t hcfg;
    pwr_ctrl_t ctl;
    logic      xtal_run, xtal_done, clk_ok;

    assign xtal_run = (state == PM_WK_CLK) && (cur_clk == CK_XTAL);
    assign clk_ok   = (cur_clk == CK_XTAL) ? xtal_done : clk_ready;

    lpm_xtal_timer #(.XTAL_SETTLE(XTAL_SETTLE)) u_xtal (
        .clk(clk), .rst(rst), .run(xtal_run), .tick(xtal_tick), .done(xtal_done)
    );

    lpm_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .wfi_req(wfi_req), .halt_req(halt_req),
        .awu_en(awu_en), .iwdg_en(iwdg_en), .cfg_ah_lowreg(cfg_ah_lowreg),
        .cfg_ah_flash_off(cfg_ah_flash_off), .cfg_halt_flash_on(cfg_halt_flash_on),
        .cfg_fast_wake(cfg_fast_wake), .clk_sw_req(clk_sw_req), .clk_sw_sel(clk_sw_sel),
        .irq_any(irq_any), .ext_wake_irq(ext_wake_irq), .awu_event(awu_event),
        .reg_ready(reg_ready), .flash_ready(flash_ready), .clk_ok(clk_ok),
        .state(state), .cur_clk(cur_clk), .hcfg(hcfg), .int_unmask(int_unmask)
    );

    lpm_power_decode u_dec (
        .state(state), .cur_clk(cur_clk), .hcfg(hcfg), .ctl(ctl)
    );

    assign pm_state    = state;
    assign master_clk  = cur_clk;
    assign cpu_clk_en  = ctl.cpu_clk_en;
    assign mvr_en      = ctl.mvr_en;
    assign lpvr_en     = ctl.lpvr_en;
    assign flash_pd    = ctl.flash_pd;
    assign rc_osc_en   = ctl.rc_en;
    assign xtal_osc_en = ctl.xtal_en;
    assign slow_osc_en = ctl.slow_en;
endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wfi_req,
    input logic       halt_req,
    input logic       cfg_fast_wake,
    input logic       ext_wake_irq,
    input logic [2:0] pm_state,
    input logic       cpu_clk_en,
    input logic       mvr_en,
    input logic       lpvr_en,
    input logic       flash_pd,
    input logic       rc_osc_en,
    input logic       xtal_osc_en,
    input logic       slow_osc_en,
    input logic [1:0] master_clk,
    input logic       int_unmask
);
    // R5
    reg_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot({mvr_en, lpvr_en}));

    // R9
    cpu_supply_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> (mvr_en && !flash_pd));

    // R7
    halt_osc_chk: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd3) |-> !(rc_osc_en || xtal_osc_en || slow_osc_en));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd3 && !ext_wake_irq) |=> (pm_state == 3'd3));

    // R2
    wait_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd0 && wfi_req && !halt_req) |=> (pm_state == 3'd1 && int_unmask));

    // R9
    wake_order_chk: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd5) |-> ($past(pm_state) == 3'd4 || $past(pm_state) == 3'd5));

    // R10
    fast_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 3'd0 && halt_req && cfg_fast_wake) |=> (master_clk == 2'd0));
endmodule

bind lpm_seq lpm_seq_chk u_chk (.*);

// File: tb/lpm_seq_bench.sv
module lpm_seq_bench;
    localparam int SETTLE = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wfi_req = 0, halt_req = 0, awu_en = 0, iwdg_en = 0;
    logic cfg_ah_lowreg = 0, cfg_ah_flash_off = 0, cfg_halt_flash_on = 0, cfg_fast_wake = 0;
    logic clk_sw_req = 0;
    logic [1:0] clk_sw_sel = 0;
    logic irq_any = 0, ext_wake_irq = 0, awu_event = 0;
    logic reg_ready = 1, flash_ready = 1, clk_ready = 1, xtal_tick = 0;
    logic [2:0] pm_state;
    logic cpu_clk_en, mvr_en, lpvr_en, flash_pd, rc_osc_en, xtal_osc_en, slow_osc_en, int_unmask;
    logic [1:0] master_clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lpm_seq #(.XTAL_SETTLE(SETTLE)) u_lpm_seq (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wake_to_run();
        reg_ready = 1; flash_ready = 1; clk_ready = 1;
        tick(); chk("R9 flash step", pm_state, 5);
        tick(); chk("R9 clock step", pm_state, 6);
        tick(); chk("R9 back to run", pm_state, 0);
        chk("R9 cpu clock on", cpu_clk_en, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst = 0;
        // r1_ reset state
        chk("R1 state", pm_state, 0);
        chk("R1 cpu", cpu_clk_en, 1);
        chk("R1 regs", {mvr_en, lpvr_en}, 2);
        chk("R1 flash", flash_pd, 0);
        chk("R1 clk", master_clk, 0);
        chk("R1 osc", {rc_osc_en, xtal_osc_en, slow_osc_en}, 4);

        // R2 wait entry
        wfi_req = 1; tick(); wfi_req = 0;
        chk("R2 state", pm_state, 1);
        chk("R2 cpu off", cpu_clk_en, 0);
        chk("R2 unmask", int_unmask, 1);
        chk("R2 power kept", {mvr_en, lpvr_en, flash_pd, rc_osc_en}, 4'b1001);
        // R3 ignored requests in wait
        halt_req = 1; clk_sw_req = 1; clk_sw_sel = 1; tick();
        halt_req = 0; clk_sw_req = 0;
        chk("R2 unmask one cycle", int_unmask, 0);
        chk("R3 halt ignored", pm_state, 1);
        chk("R3 switch ignored", master_clk, 0);
        irq_any = 1; tick(); irq_any = 0;
        chk("R3 exit", pm_state, 0);

        // R4 wfi and halt together: halt wins
        wfi_req = 1; halt_req = 1; tick(); wfi_req = 0; halt_req = 0;
        chk("R4 halt priority", pm_state, 3);
        chk("R4 no unmask", int_unmask, 0);
        ext_wake_irq = 1; tick(); ext_wake_irq = 0;
        chk("R8 wake", pm_state, 4);
        wake_to_run();

        // R4 R5 R6 R7 R8 sweep over all configurations
        for (int v = 0; v < 32; v++) begin
            automatic bit a = v[0], w = v[1], lp = v[2], fo = v[3], fk = v[4];
            automatic bit ah = a | w;
            awu_en = a; iwdg_en = w; cfg_ah_lowreg = lp;
            cfg_ah_flash_off = fo; cfg_halt_flash_on = fk;
            halt_req = 1; tick(); halt_req = 0;
            chk("R4 mode", pm_state, ah ? 2 : 3);
            chk("R5 lpvr", lpvr_en, ah ? lp : 1);
            chk("R5 mvr", mvr_en, ah ? !lp : 0);
            chk("R6 flash", flash_pd, ah ? fo : !fk);
            chk("R7 osc", {rc_osc_en, xtal_osc_en, slow_osc_en}, ah ? 1 : 0);
            chk("R9 cpu off", cpu_clk_en, 0);
            // R6 changes during halt have no effect
            cfg_ah_flash_off = !fo; cfg_halt_flash_on = !fk; cfg_ah_lowreg = !lp;
            reg_ready = 0;
            irq_any = 1; tick(); irq_any = 0;
            chk("R8 irq_any ignored", pm_state, ah ? 2 : 3);
            chk("R6 flash held", flash_pd, ah ? fo : !fk);
            awu_event = 1; tick(); awu_event = 0;
            chk("R8 awu event", pm_state, ah ? 4 : 3);
            if (!ah) begin
                ext_wake_irq = 1; tick(); ext_wake_irq = 0;
                chk("R8 ext wake", pm_state, 4);
            end
            chk("R9 main reg in wake", mvr_en, 1);
            tick();
            chk("R9 waits regulator", pm_state, 4);
            wake_to_run();
        end
        awu_en = 0; iwdg_en = 0;

        // R9 ordering with readiness withheld
        halt_req = 1; tick(); halt_req = 0;
        reg_ready = 1; flash_ready = 0; clk_ready = 0;
        ext_wake_irq = 1; tick(); ext_wake_irq = 0;
        tick(); chk("R9 at flash", pm_state, 5);
        tick(); chk("R9 holds flash", pm_state, 5);
        reg_ready = 0; flash_ready = 1;
        tick(); chk("R9 at clock", pm_state, 6);
        tick(); chk("R9 holds clock", pm_state, 6);
        chk("R9 rc on in clock step", rc_osc_en, 1);
        clk_ready = 1; tick(); chk("R9 run", pm_state, 0);

        // R12 clock switching
        clk_sw_req = 1; clk_sw_sel = 3; tick();
        chk("R12 code 3 ignored", master_clk, 0);
        clk_sw_sel = 1; tick(); clk_sw_req = 0;
        chk("R12 crystal", master_clk, 1);
        chk("R7 crystal osc", {rc_osc_en, xtal_osc_en, slow_osc_en}, 2);

        // R11 crystal settle count, clk_ready ignored
        halt_req = 1; tick(); halt_req = 0;
        reg_ready = 1; flash_ready = 1; clk_ready = 1; xtal_tick = 0;
        ext_wake_irq = 1; tick(); ext_wake_irq = 0;
        tick(); tick();
        chk("R11 at clock step", pm_state, 6);
        chk("R11 crystal enabled", xtal_osc_en, 1);
        tick(); tick();
        chk("R11 no ticks holds", pm_state, 6);
        xtal_tick = 1;
        for (int i = 0; i < SETTLE - 1; i++) tick();
        chk("R11 one tick short", pm_state, 6);
        tick();
        chk("R11 settled", pm_state, 0);
        xtal_tick = 0;

        // R10 fast wake from crystal, crystal ticks do not release
        cfg_fast_wake = 1;
        halt_req = 1; tick(); halt_req = 0;
        chk("R10 rc selected", master_clk, 0);
        clk_ready = 0; xtal_tick = 1;
        ext_wake_irq = 1; tick(); ext_wake_irq = 0;
        tick(); tick();
        chk("R10 wait rc", pm_state, 6);
        chk("R10 rc osc on", {rc_osc_en, xtal_osc_en}, 2);
        clk_ready = 1; xtal_tick = 0; tick();
        chk("R10 run on rc", pm_state, 0);

        // R12 switch and halt in the same cycle
        cfg_fast_wake = 0;
        clk_sw_req = 1; clk_sw_sel = 2; halt_req = 1; tick();
        clk_sw_req = 0; halt_req = 0;
        chk("R12 switch with halt", master_clk, 2);
        ext_wake_irq = 1; tick(); ext_wake_irq = 0;
        wake_to_run();
        chk("R7 slow osc in run", {rc_osc_en, xtal_osc_en, slow_osc_en}, 1);
        cfg_fast_wake = 1;
        clk_sw_req = 1; clk_sw_sel = 1; halt_req = 1; tick();
        clk_sw_req = 0; halt_req = 0;
        chk("R12 fast wake overrides switch", master_clk, 0);
        ext_wake_irq = 1; tick(); ext_wake_irq = 0;
        wake_to_run();

        // R1 reset from a halt
        halt_req = 1; tick(); halt_req = 0;
        rst = 1; tick(); rst = 0;
        chk("R1 reset from halt", pm_state, 0);
        chk("R1 reset clk", master_clk, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule